// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block moves a CAN controller between its three operating modes: initialization, normal and low-power sleep. Software drives two level request inputs: one for initialization and one for sleep. The block answers on two acknowledge outputs. Normal mode has no acknowledge of its own. It is the state in which neither acknowledge is high.

The block never enters normal mode until the bus has been seen idle. It counts consecutive recessive samples of the receive line, taken only on the bit-sample strobe. Until that count completes, the block keeps showing the acknowledge of the mode it is leaving. The block comes out of reset asleep. In that state it enables a weak pull-up on the transmit pin. The pull-up stays on until the first real mode change. An optional auto-wakeup lets a falling edge on the receive line start the exit from sleep while the sleep request is still held.

Top module: `can_mode_seq`

## Requirements
- R1: Reset leaves the block asleep: `sleepAck`=1, `initAck`=0, `txPullupEn`=1.
- R2: With `initReq` high, `initAck` rises on the clock edge that samples the request, and it stays high while the request is held.
- R3: When `initReq` and `sleepReq` are both high, the block goes to initialization, from any mode.
- R4: Normal mode (both acknowledges low) is entered only after 11 consecutive recessive (`rxLine`=1) samples taken on `sampleStb`. Until the 11th sample, the acknowledge of the mode being left stays high.
- R5: A dominant (`rxLine`=0) sample taken on `sampleStb` while synchronizing restarts the count of 11 from zero.
- R6: Values of `rxLine` in cycles without `sampleStb` do not affect the idle count.
- R7: If the request that started a mode exit is re-asserted before normal mode is reached, the block returns to the old mode. The acknowledge never drops, and a later exit needs a full new count of 11.
- R8: `txPullupEn` is high from reset until the first edge on which a different mode is entered and acknowledged. After that it stays low until the next reset.
- R9: Wakeup from sleep. A falling edge on `rxLine` in sleep starts synchronization only when `autoWakeEn` is 1. After such a wakeup, `sleepReq` is ignored until it has been low for at least one cycle.
- R10: In normal mode, `initReq` or `sleepReq` raises the matching acknowledge on the next clock edge.
- R11: Dropping `initReq` while `sleepReq` is high moves the block from initialization directly to sleep, with no bus synchronization.
- R12: `initAck` and `sleepAck` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initReq | input | 1 | Software request for initialization mode |
| sleepReq | input | 1 | Software request for sleep mode |
| autoWakeEn | input | 1 | Lets a receive-line falling edge wake the block from sleep |
| rxLine | input | 1 | Sampled receive line (1 = recessive) |
| sampleStb | input | 1 | Bit-sample strobe, one clock wide |
| initAck | output | 1 | Initialization mode entered |
| sleepAck | output | 1 | Sleep mode entered |
| txPullupEn | output | 1 | Enable of the weak pull-up on the transmit pin |

## Verification
The bench counts idle samples up to the exact edge where normal mode is reached. A design that is off by one on the count of 11 leaves normal mode one strobe early or late. The bench places a dominant sample in the middle of the count, both with and without the strobe. This catches a design that fails to restart the count, and one that restarts it on samples it should ignore.

Withdrawn exits are tested from both initialization and sleep. A design that drops the acknowledge, or keeps the old partial count, shows up as a glitch on the acknowledge or as an early entry into normal mode. The bench also checks that the pull-up stays on when the block returns to sleep with no mode change. It checks that a falling edge with `autoWakeEn` low is ignored. It checks that a still-held `sleepReq` does not put the block straight back to sleep after an auto-wakeup.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_NORMAL = 2'd3
  } modeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdle;   // restart the idle counter
    logic cntEn;     // synchronizing: count strobed samples
    logic modeDone;  // a new mode is entered this edge
    logic autoWoke;  // exit from sleep caused by a wake edge
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic idleDone;      // last required recessive sample seen
    logic wakeEdge;      // falling edge on the receive line
    logic sleepBlocked;  // sleep request masked after auto-wakeup
  } dpStat_t;

endpackage

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctrl,
  input  logic    sleepReq,
  input  logic    rxLine,
  input  logic    sampleStb,
  output dpStat_t stat,
  output logic    txPullupEn
);

  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] idleCnt;
  logic             rxPrev;
  logic             blockQ;
  logic             pullQ;
  logic             strobed;

  assign strobed = ctrl.cntEn && sampleStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctrl.clrIdle) begin
      idleCnt <= '0;
    end else if (strobed) begin
      if (!rxLine || idleCnt == LAST) idleCnt <= '0;
      else                            idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev <= 1'b1;
      blockQ <= 1'b0;
      pullQ  <= 1'b1;
    end else begin
      rxPrev <= rxLine;
      if (ctrl.autoWoke)  blockQ <= 1'b1;
      else if (!sleepReq) blockQ <= 1'b0;
      if (ctrl.modeDone)  pullQ  <= 1'b0;
    end
  end

  assign stat.idleDone     = strobed && rxLine && (idleCnt == LAST);
  assign stat.wakeEdge     = rxPrev && !rxLine;
  assign stat.sleepBlocked = blockQ;
  assign txPullupEn        = pullQ;

  // R8
  pullup_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txPullupEn |=> !txPullupEn);

  // R5
  dom_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntEn && sampleStb && !rxLine) |=> (idleCnt == '0));

  // R6
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !ctrl.clrIdle) |=> $stable(idleCnt));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt < CNT_W'(IDLE_BITS));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    initReq,
  input  logic    sleepReq,
  input  logic    autoWakeEn,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    initAck,
  output logic    sleepAck
);

  modeState_t stateQ, stateD;
  logic       fromInitQ, fromInitD;
  logic       sleepOk;

  assign sleepOk = sleepReq && !stat.sleepBlocked;

  always_comb begin
    stateD        = stateQ;
    fromInitD     = fromInitQ;
    ctrl.clrIdle  = 1'b0;
    ctrl.autoWoke = 1'b0;
    unique case (stateQ)
      MODE_SLEEP: begin
        if (initReq) begin
          stateD = MODE_INIT;
        end else if (!sleepReq || (autoWakeEn && stat.wakeEdge)) begin
          stateD        = MODE_SYNC;
          fromInitD     = 1'b0;
          ctrl.clrIdle  = 1'b1;
          ctrl.autoWoke = sleepReq;
        end
      end
      MODE_INIT: begin
        if (!initReq) begin
          if (sleepOk) begin
            stateD = MODE_SLEEP;
          end else begin
            stateD       = MODE_SYNC;
            fromInitD    = 1'b1;
            ctrl.clrIdle = 1'b1;
          end
        end
      end
      MODE_SYNC: begin
        if (initReq)                     stateD = MODE_INIT;
        else if (!fromInitQ && sleepOk)  stateD = MODE_SLEEP;
        else if (stat.idleDone)          stateD = MODE_NORMAL;
      end
      MODE_NORMAL: begin
        if (initReq)      stateD = MODE_INIT;
        else if (sleepOk) stateD = MODE_SLEEP;
      end
      default: stateD = MODE_SLEEP;
    endcase
  end

  assign initAck  = (stateQ == MODE_INIT)  || (stateQ == MODE_SYNC && fromInitQ);
  assign sleepAck = (stateQ == MODE_SLEEP) || (stateQ == MODE_SYNC && !fromInitQ);

  assign ctrl.cntEn    = (stateQ == MODE_SYNC);
  assign ctrl.modeDone = (stateD == MODE_INIT && !initAck)
                      || (stateD == MODE_SLEEP && !sleepAck)
                      || (stateD == MODE_NORMAL && stateQ != MODE_NORMAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= MODE_SLEEP;
      fromInitQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      fromInitQ <= fromInitD;
    end
  end

  // R12
  acks_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(initAck && sleepAck));

  // R3
  init_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (stateQ == MODE_INIT));

  // R4
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == MODE_NORMAL && $past(stateQ) != MODE_NORMAL) |-> $past(stat.idleDone));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic initReq,
  input  logic sleepReq,
  input  logic autoWakeEn,
  input  logic rxLine,
  input  logic sampleStb,
  output logic initAck,
  output logic sleepAck,
  output logic txPullupEn
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  can_mode_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .initReq    (initReq),
    .sleepReq   (sleepReq),
    .autoWakeEn (autoWakeEn),
    .stat       (dpStat),
    .ctrl       (dpCtrl),
    .initAck    (initAck),
    .sleepAck   (sleepAck)
  );

  can_mode_dp #(.IDLE_BITS(IDLE_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (dpCtrl),
    .sleepReq   (sleepReq),
    .rxLine     (rxLine),
    .sampleStb  (sampleStb),
    .stat       (dpStat),
    .txPullupEn (txPullupEn)
  );

endmodule

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, sleepReq = 1'b0, autoWakeEn = 1'b0;
  logic rxLine = 1'b1, sampleStb = 1'b0;
  logic initAck, sleepAck, txPullupEn;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_mode_seq u_can_mode_seq (
    .clk(clk), .rstN(rstN), .initReq(initReq), .sleepReq(sleepReq),
    .autoWakeEn(autoWakeEn), .rxLine(rxLine), .sampleStb(sampleStb),
    .initAck(initAck), .sleepAck(sleepAck), .txPullupEn(txPullupEn)
  );

  // {initReq, sleepReq, autoWakeEn, rxLine, sampleStb, expInit, expSleep, expPull}
  localparam logic [7:0] VEC [16] = '{
    8'b1001_0100, 8'b1001_0100, 8'b0001_1100, 8'b0001_1100,
    8'b0001_1100, 8'b0001_1100, 8'b0001_1100, 8'b0001_1100,
    8'b0001_1100, 8'b0001_1100, 8'b0001_1100, 8'b0001_1100,
    8'b0001_1100, 8'b0001_1000, 8'b0101_0010, 8'b1101_0100
  };

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {initAck, sleepAck, txPullupEn};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic i, input logic s, input logic a,
                      input logic r, input logic b);
    initReq = i; sleepReq = s; autoWakeEn = a; rxLine = r; sampleStb = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(initReq, sleepReq, autoWakeEn, 1'b1, 1'b1);
  endtask

  task automatic doReset(input logic s);
    rstN = 1'b0;
    initReq = 1'b0; sleepReq = s; autoWakeEn = 1'b0; rxLine = 1'b1; sampleStb = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(1'b0);
    check("R1 reset state", 3'b011);

    // table walk: init entry, sync of 11, normal, sleep, both requests
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3]);
      check($sformatf("R2 R3 R4 R8 R10 vector %0d", k), VEC[k][2:0]);
    end

    // R6: dominant without strobe is ignored
    doReset(1'b0);
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    idle(5);
    step(0, 0, 0, 0, 0);
    idle(5);
    check("R6 count kept across unstrobed dominant", 3'b100);
    idle(1);
    check("R6 normal after 11 strobed samples", 3'b000);

    // R5: dominant strobed sample restarts count
    step(1, 0, 0, 1, 0);
    check("R10 init from normal", 3'b100);
    step(0, 0, 0, 1, 0);
    idle(5);
    step(0, 0, 0, 0, 1);
    idle(10);
    check("R5 ten after restart not enough", 3'b100);
    idle(1);
    check("R5 eleventh after restart reaches normal", 3'b000);

    // R7 from init
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    idle(4);
    step(1, 0, 0, 1, 1);
    check("R7 init re-request keeps ack", 3'b100);
    step(0, 0, 0, 1, 0);
    idle(10);
    check("R7 count restarted after withdrawal", 3'b100);
    idle(1);
    check("R7 normal after fresh count", 3'b000);

    // R10 sleep from normal, R11 init to sleep direct
    step(0, 1, 0, 1, 0);
    check("R10 sleep from normal", 3'b010);
    step(1, 1, 0, 1, 0);
    check("R3 init over sleep", 3'b100);
    step(0, 1, 0, 1, 0);
    check("R11 init straight to sleep", 3'b010);

    // R7/R8 from reset sleep
    doReset(1'b0);
    step(0, 0, 0, 1, 1);
    check("R7 sync holds sleep ack", 3'b011);
    idle(3);
    step(0, 1, 0, 1, 0);
    check("R8 withdrawn wake keeps pull-up on", 3'b011);

    // R9 wake edge handling
    step(0, 1, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check("R9 edge ignored without enable", 3'b011);
    step(0, 1, 1, 1, 0);
    step(0, 1, 1, 0, 0);
    check("R9 wake edge starts sync", 3'b011);
    idle(11);
    check("R9 normal after auto wake", 3'b000);
    step(0, 1, 1, 1, 0);
    step(0, 1, 1, 1, 0);
    check("R9 held sleep request masked", 3'b000);
    step(0, 0, 1, 1, 0);
    step(0, 1, 1, 1, 0);
    check("R9 sleep after request re-raised", 3'b010);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule